// File: doc/BRIEF.md
# Two-Way Registered Bus Transceiver

An 18-bit transceiver that moves data between an A side and a B side, with a separate register path for each direction. Each path keeps one stored word and works in one of three ways. With its latch enable high the path is transparent and passes the input through. With the latch enable low and its transfer clock steady, the path holds its word. With the latch enable low, a falling edge of the transfer clock loads the present input. An output enable decides whether the far side is driven. The A-to-B enable is active high and the B-to-A enable is active low.

The block runs on a fast system clock. Latch-enable and transfer-clock pins pass through a two-flop synchronizer, and the transfer-clock edge is found on the synchronized samples. Each bus side is a separate input, output and drive-enable port. While its drive enable is low, an output port reads as zero. Data inputs are taken as synchronous to the system clock.

Top module: `ubt_xcvr`

## Requirements
- R1: Once a latch enable has been high for the two synchronizer cycles, the path is transparent. After every system clock edge the path's 18-bit output shows the input sampled at that edge, on all bits.
- R2: With the latch enable low and the transfer clock steady high or low, the stored word is held and input changes have no effect on the output.
- R3: With the latch enable low, a synchronized high-to-low change of the transfer clock loads the input present at the edge where the change is detected.
- R4: The A-to-B output enable is active high. Its registered state drives `b_oe_o`, and `b_o` is all zeros while `b_oe_o` is low.
- R5: The B-to-A path behaves as in R1 to R3 with its own controls. Its output enable `oe_ba_ni` is active low, and `a_o` is all zeros while `a_oe_o` is low.
- R6: If the latch enable falls while the transfer clock is low, the last word passed in transparent mode stays stored.
- R7: The output enables do not touch storage. Words loaded or held while the outputs are disabled appear when the outputs are enabled again.
- R8: A low-to-high change of the transfer clock loads nothing.
- R9: If a falling transfer-clock edge is detected while the latch enable is high, the transparent behaviour of R1 applies.
- R10: While `rst_ni` is low, both stored words are zero and both drive enables are low, whatever the control inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| oe_ab_i | input | 1 | A-to-B output enable, active high |
| le_ab_i | input | 1 | A-to-B latch enable |
| tclk_ab_i | input | 1 | A-to-B transfer clock, loads on its falling edge |
| oe_ba_ni | input | 1 | B-to-A output enable, active low |
| le_ba_i | input | 1 | B-to-A latch enable |
| tclk_ba_i | input | 1 | B-to-A transfer clock, loads on its falling edge |
| a_i | input | 18 | A-side data in |
| b_i | input | 18 | B-side data in |
| a_o | output | 18 | A-side data out (zero when not driven) |
| a_oe_o | output | 1 | A-side drive enable |
| b_o | output | 18 | B-side data out (zero when not driven) |
| b_oe_o | output | 1 | B-side drive enable |

## Verification
The assertions check on every cycle that the stored word follows the input while transparent (R1, R9), that it loads on a detected fall (R3), that it holds otherwise (R2), that a released output reads zero (R4, R5) and the reset state (R10). The bench's scenarios are needed to show the rest, because these depend on the order of control events seen at the ports. That covers the two-cycle synchronizer latency, the value kept when the latch enable drops with the clock low (R6), the absence of loading on a rising edge (R8) and the data that reappears after a disabled period (R7).

// File: rtl/ubt_pkg.sv
package ubt_pkg;
  localparam int unsigned DATA_W    = 18;
  localparam int unsigned SYNC_STGS = 2;

  typedef struct packed {
    logic le;
    logic tclk;
  } ubt_ctl_t;

  localparam int unsigned CTL_W = $bits(ubt_ctl_t);
endpackage

// File: rtl/ubt_sync.sv
module ubt_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    stg_q[g] <= '0;
      else if (g == 0) stg_q[g] <= d_i;
      else             stg_q[g] <= stg_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ubt_store.sv
module ubt_store #(
  parameter int unsigned W = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         le_s_i,
  input  logic         tclk_s_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] q_o
);
  logic tclk_prev_q;
  logic fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tclk_prev_q <= 1'b0;
    else         tclk_prev_q <= tclk_s_i;
  end

  assign fall = tclk_prev_q & ~tclk_s_i;

  // transparent wins over a simultaneous capture strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (le_s_i) q_o <= din_i;
    else if (fall)   q_o <= din_i;
  end

  a_r1_transparent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    le_s_i |=> (q_o == $past(din_i)));
  a_r9_le_over_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (le_s_i && fall) |=> (q_o == $past(din_i)));
  a_r3_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_s_i && fall) |=> (q_o == $past(din_i)));
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_s_i && !fall) |=> $stable(q_o));
  a_r10_store_clear: assert property (@(posedge clk_i)
    !rst_ni |-> (q_o == '0));
endmodule

// File: rtl/ubt_path.sv
module ubt_path
  import ubt_pkg::*;
#(
  parameter int unsigned W        = DATA_W,
  parameter bit          OE_LOW   = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         oe_i,
  input  logic         le_i,
  input  logic         tclk_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] dout_o,
  output logic         drive_o
);
  ubt_ctl_t ctl_raw, ctl_s;
  logic [W-1:0] store_q;
  logic oe_q;

  assign ctl_raw.le   = le_i;
  assign ctl_raw.tclk = tclk_i;

  ubt_sync #(.W(CTL_W), .STAGES(SYNC_STGS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (ctl_raw),
    .q_o    (ctl_s)
  );

  ubt_store #(.W(W)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .le_s_i   (ctl_s.le),
    .tclk_s_i (ctl_s.tclk),
    .din_i    (din_i),
    .q_o      (store_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oe_q <= 1'b0;
    else         oe_q <= oe_i ^ OE_LOW;
  end

  assign drive_o = oe_q;
  assign dout_o  = oe_q ? store_q : '0;

  a_r4_released_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drive_o |-> (dout_o == '0));
  a_r5_oe_polarity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (drive_o == ($past(oe_i) ^ OE_LOW)));
  a_r10_drive_off: assert property (@(posedge clk_i)
    !rst_ni |-> !drive_o);
endmodule

// File: rtl/ubt_xcvr.sv
module ubt_xcvr
  import ubt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              oe_ab_i,
  input  logic              le_ab_i,
  input  logic              tclk_ab_i,
  input  logic              oe_ba_ni,
  input  logic              le_ba_i,
  input  logic              tclk_ba_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] a_o,
  output logic              a_oe_o,
  output logic [DATA_W-1:0] b_o,
  output logic              b_oe_o
);
  ubt_path #(.W(DATA_W), .OE_LOW(1'b0)) u_ab (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .oe_i    (oe_ab_i),
    .le_i    (le_ab_i),
    .tclk_i  (tclk_ab_i),
    .din_i   (a_i),
    .dout_o  (b_o),
    .drive_o (b_oe_o)
  );

  ubt_path #(.W(DATA_W), .OE_LOW(1'b1)) u_ba (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .oe_i    (oe_ba_ni),
    .le_i    (le_ba_i),
    .tclk_i  (tclk_ba_i),
    .din_i   (b_i),
    .dout_o  (a_o),
    .drive_o (a_oe_o)
  );
endmodule

// File: tb/ubt_xcvr_tb.sv
module ubt_xcvr_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic oe_ab = 1'b1, le_ab = 1'b1, tclk_ab = 1'b1;
  logic oe_ba_n = 1'b0, le_ba = 1'b1, tclk_ba = 1'b1;
  logic [17:0] a_in = '0, b_in = '0;
  logic [17:0] a_out, b_out;
  logic a_oe, b_oe;

  int total = 0;
  int bad = 0;
  string phase = "R10";
  bit done = 0;

  always #2 clk = ~clk;

  ubt_xcvr u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .oe_ab_i(oe_ab), .le_ab_i(le_ab), .tclk_ab_i(tclk_ab),
    .oe_ba_ni(oe_ba_n), .le_ba_i(le_ba), .tclk_ba_i(tclk_ba),
    .a_i(a_in), .b_i(b_in),
    .a_o(a_out), .a_oe_o(a_oe), .b_o(b_out), .b_oe_o(b_oe)
  );

  // reference model: histories hold control samples of the last three edges
  bit le_ab_h[$] = '{0, 0, 0};
  bit tc_ab_h[$] = '{0, 0, 0};
  bit le_ba_h[$] = '{0, 0, 0};
  bit tc_ba_h[$] = '{0, 0, 0};
  logic [17:0] st_ab = '0, st_ba = '0;
  bit en_ab = 0, en_ba = 0;

  task automatic model_dir(input bit le, input bit tc, input logic [17:0] din,
                           ref bit leh[$], ref bit tch[$], ref logic [17:0] st);
    bit eff_le, dropped;
    eff_le  = leh[1];
    dropped = tch[2] && !tch[1];
    if (eff_le || dropped) st = din;
    leh.push_front(le); void'(leh.pop_back());
    tch.push_front(tc); void'(tch.pop_back());
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      le_ab_h = '{0, 0, 0}; tc_ab_h = '{0, 0, 0};
      le_ba_h = '{0, 0, 0}; tc_ba_h = '{0, 0, 0};
      st_ab = '0; st_ba = '0; en_ab = 0; en_ba = 0;
    end else begin
      model_dir(le_ab, tclk_ab, a_in, le_ab_h, tc_ab_h, st_ab);
      model_dir(le_ba, tclk_ba, b_in, le_ba_h, tc_ba_h, st_ba);
      en_ab = oe_ab;
      en_ba = !oe_ba_n;
    end
  end

  task automatic chk(input string what, input logic [17:0] act, input logic [17:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", phase, what, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk("b_o",    b_out, en_ab ? st_ab : 18'h0);
      chk("b_oe_o", {17'h0, b_oe}, {17'h0, en_ab});
      chk("a_o",    a_out, en_ba ? st_ba : 18'h0);
      chk("a_oe_o", {17'h0, a_oe}, {17'h0, en_ba});
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    // R10: reset forces storage zero and drivers off despite enables
    a_in = 18'h3ffff; b_in = 18'h2aaaa;
    tick(4);
    @(negedge clk); rst_n = 1'b1;
    le_ab = 1'b0; le_ba = 1'b0; oe_ab = 1'b0; oe_ba_n = 1'b1;
    tick(5);

    // R1: transparent A-to-B, new word every cycle
    phase = "R1";
    oe_ab = 1'b1; le_ab = 1'b1; tclk_ab = 1'b0;
    for (int i = 0; i < 12; i++) begin
      a_in = 18'($urandom); tick();
    end
    a_in = 18'h3ffff; tick(); a_in = 18'h00000; tick(); a_in = 18'h2aaaa; tick();

    // R6: latch enable falls while transfer clock low
    phase = "R6";
    le_ab = 1'b0; a_in = 18'h15555; tick();
    for (int i = 0; i < 6; i++) begin
      a_in = 18'($urandom); tick();
    end

    // R8: rising transfer clock does not load
    phase = "R8";
    tclk_ab = 1'b1; a_in = 18'h0f0f0; tick(5);

    // R2: held with transfer clock steady high, input changes ignored
    phase = "R2";
    for (int i = 0; i < 6; i++) begin
      a_in = 18'($urandom); tick();
    end

    // R3: falling edge loads, then hold again
    phase = "R3";
    a_in = 18'h12345; tclk_ab = 1'b0; tick(4);
    a_in = 18'h3c3c3; tick(3);
    tclk_ab = 1'b1; tick(3); a_in = 18'h0abcd; tclk_ab = 1'b0; tick(4);

    // R9: falling edge while transparent, output keeps following
    phase = "R9";
    le_ab = 1'b1; tick(3);
    for (int i = 0; i < 8; i++) begin
      tclk_ab = ~tclk_ab; a_in = 18'($urandom); tick();
    end

    // R4: A-to-B enable low releases B side
    phase = "R4";
    oe_ab = 1'b0; a_in = 18'h11111; tick(4);

    // R7: load while disabled, value appears on re-enable
    phase = "R7";
    le_ab = 1'b0; tclk_ab = 1'b1; tick(4);
    a_in = 18'h2468a; tclk_ab = 1'b0; tick(4);
    a_in = 18'h00001; oe_ab = 1'b1; tick(4);

    // R5: B-to-A direction with active-low enable
    phase = "R5";
    oe_ba_n = 1'b0; le_ba = 1'b1; tclk_ba = 1'b1;
    for (int i = 0; i < 6; i++) begin
      b_in = 18'($urandom); tick();
    end
    le_ba = 1'b0; tick(4);
    b_in = 18'h33333; tick(3);
    tclk_ba = 1'b0; tick(4);
    b_in = 18'h0; tclk_ba = 1'b1; tick(4);
    oe_ba_n = 1'b1; tick(3);
    b_in = 18'h1f00f; tclk_ba = 1'b0; tick(4);
    oe_ba_n = 1'b0; tick(3);

    // R10: reset mid-run with enables active
    phase = "R10";
    @(negedge clk); rst_n = 1'b0;
    tick(3);
    @(negedge clk); rst_n = 1'b1;
    tick(3);

    done = 1;
    finish_run();
  end
endmodule